// File: doc/BRIEF.md
# Multiport frame match classifier

The classifier looks at the header of each incoming Ethernet frame (destination MAC address and EtherType) and compares it against six programmable match entries. Each entry carries a 48-bit MAC key, a 16-bit EtherType key, a 2-bit compare mode and a 32-bit destination port bitmask. When a header is presented, the block reports, one cycle later, whether any entry matched, which entry won, the port bitmask to forward to, and whether the frame should get an ingress timestamp.

A typical use is trapping precision time protocol frames (EtherType 0x88F7) to the CPU port. Software programs an entry to compare EtherType only, sets the bit of the CPU port in that entry's vector, and enables the timestamp request for entry 0. The CPU port number is a property of the vector contents, not of the block, so any port index up to 31 works.

Configuration goes through a simple write port: `cfg_addr[4:3]` selects the register kind and `cfg_addr[2:0]` the entry. Kind 0 is the control word, kind 1 the low 32 bits of an entry's 64-bit key, kind 2 its high 32 bits, and kind 3 its vector.

Top module: `mpm_classifier`

## Requirements
- R1: After reset all outputs are 0, and every entry is disabled, so any header (including all-zero MAC and EtherType) gives `res_match` = 0.
- R2: An entry in mode 1 matches when `hdr_dmac` equals key bits 47:0 (low word = key bits 31:0, high word bits 15:0 = key bits 47:32), whatever the EtherType.
- R3: An entry in mode 2 matches when `hdr_etype` equals key bits 63:48 (high word bits 31:16), whatever the MAC.
- R4: An entry in mode 3 matches only when both MAC and EtherType equal their keys.
- R5: An entry in mode 0 never matches, even if its keys equal the header.
- R6: When several entries match, the lowest-numbered one wins; `res_idx` is its number and `res_vec` its full 32-bit vector.
- R7: With no matching entry, `res_match`, `res_idx`, `res_vec` and `res_ts` are all 0 in the result cycle.
- R8: `res_ts` is 1 exactly when the winning entry is entry 0 and control bit 15 is 1; otherwise it is 0.
- R9: The result appears in the cycle after the `hdr_valid` cycle with `res_valid` = 1 and lasts one cycle; in cycles with no result every output is 0.
- R10: Entry i's mode sits in control bits 2i+1:2i. A write in the same cycle as a header takes effect for the next header, and a write to entry number 6 or 7 changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | [4:3] register kind, [2:0] entry number |
| cfg_wdata | input | 32 | Write data |
| hdr_valid | input | 1 | Header strobe, one cycle per frame |
| hdr_dmac | input | 48 | Destination MAC of the frame |
| hdr_etype | input | 16 | EtherType of the frame |
| res_valid | output | 1 | Result cycle marker |
| res_match | output | 1 | Some enabled entry matched |
| res_idx | output | 3 | Number of the winning entry |
| res_vec | output | 32 | Destination port bitmask of the winner |
| res_ts | output | 1 | Ingress timestamp request |

## Verification
Every result is due exactly one clock after the edge that samples `hdr_valid`, since the compare and priority logic is combinational and only the result register lies on the path. The bench drives a header at a falling edge and reads all five outputs at the next falling edge, after the single rising edge in between; one cycle later it reads them again to confirm the pulse has gone. Register writes land on a rising edge, so a write issued alongside a header is checked against the old configuration and the following header against the new one.

// File: rtl/mpm_pkg.sv
package mpm_pkg;

    // Compare modes of one entry
    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_MAC   = 2'd1,
        MODE_ETYPE = 2'd2,
        MODE_BOTH  = 2'd3
    } mpm_mode_e;

    // Register kinds selected by cfg_addr[4:3]
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_KEYLO = 2'd1,
        SEL_KEYHI = 2'd2,
        SEL_VEC   = 2'd3
    } mpm_sel_e;

    localparam int unsigned CTRL_W   = 16;
    localparam int unsigned TS_BIT   = 15;
    localparam int unsigned KEY_W    = 64;
    localparam int unsigned MAC_W    = 48;
    localparam int unsigned ETYPE_W  = 16;
    localparam int unsigned CFG_AW   = 5;
    localparam int unsigned CFG_DW   = 32;
    localparam int unsigned ENT_SEL_W = 3;

endpackage

// File: rtl/mpm_regs.sv
module mpm_regs
    import mpm_pkg::*;
#(
    parameter int unsigned N_ENT = 6,
    parameter int unsigned VEC_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [CFG_AW-1:0]             cfg_addr,
    input  logic [CFG_DW-1:0]             cfg_wdata,
    output mpm_mode_e                     ent_mode  [N_ENT],
    output logic [N_ENT-1:0][MAC_W-1:0]   ent_mac,
    output logic [N_ENT-1:0][ETYPE_W-1:0] ent_etype,
    output logic [N_ENT-1:0][VEC_W-1:0]   ent_vec,
    output logic                          ts_en
);

    localparam int unsigned HALF_W = KEY_W / 2;

    typedef struct packed {
        logic [CTRL_W-1:0]            ctrl;
        logic [N_ENT-1:0][KEY_W-1:0]  key;
        logic [N_ENT-1:0][VEC_W-1:0]  vec;
    } regs_t;

    regs_t st_d, st_q;

    mpm_sel_e              sel;
    logic [ENT_SEL_W-1:0]  ent;

    assign sel = mpm_sel_e'(cfg_addr[CFG_AW-1 -: 2]);
    assign ent = cfg_addr[ENT_SEL_W-1:0];

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            if (sel == SEL_CTRL) begin
                st_d.ctrl = cfg_wdata[CTRL_W-1:0];
            end else begin
                for (int i = 0; i < int'(N_ENT); i++) begin
                    if (int'(ent) == i) begin
                        case (sel)
                            SEL_KEYLO: st_d.key[i][HALF_W-1:0]      = cfg_wdata;
                            SEL_KEYHI: st_d.key[i][KEY_W-1:HALF_W]  = cfg_wdata;
                            SEL_VEC:   st_d.vec[i]                  = VEC_W'(cfg_wdata);
                            default:   ;
                        endcase
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar g = 0; g < int'(N_ENT); g++) begin : g_fields
            assign ent_mode[g]  = mpm_mode_e'(st_q.ctrl[2*g +: 2]);
            assign ent_mac[g]   = st_q.key[g][MAC_W-1:0];
            assign ent_etype[g] = st_q.key[g][KEY_W-1 -: ETYPE_W];
            assign ent_vec[g]   = st_q.vec[g];
        end
    endgenerate

    assign ts_en = st_q.ctrl[TS_BIT];

endmodule

// File: rtl/mpm_entry_cmp.sv
module mpm_entry_cmp
    import mpm_pkg::*;
(
    input  mpm_mode_e            mode,
    input  logic [MAC_W-1:0]     key_mac,
    input  logic [ETYPE_W-1:0]   key_etype,
    input  logic [MAC_W-1:0]     frm_mac,
    input  logic [ETYPE_W-1:0]   frm_etype,
    output logic                 hit
);

    logic mac_eq;
    logic etype_eq;

    assign mac_eq   = (frm_mac == key_mac);
    assign etype_eq = (frm_etype == key_etype);

    always_comb begin
        unique case (mode)
            MODE_MAC:   hit = mac_eq;
            MODE_ETYPE: hit = etype_eq;
            MODE_BOTH:  hit = mac_eq && etype_eq;
            default:    hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/mpm_prio.sv
module mpm_prio #(
    parameter int unsigned N_ENT = 6,
    localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [N_ENT-1:0]  hits,
    output logic              found,
    output logic [IDX_W-1:0]  win
);

    // Scan from the top down so the lowest hit is written last
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int i = int'(N_ENT) - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found = 1'b1;
                win   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/mpm_classifier.sv
module mpm_classifier
    import mpm_pkg::*;
#(
    parameter int unsigned N_ENT = 6,
    parameter int unsigned VEC_W = 32,
    localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [4:0]          cfg_addr,
    input  logic [31:0]         cfg_wdata,
    input  logic                hdr_valid,
    input  logic [47:0]         hdr_dmac,
    input  logic [15:0]         hdr_etype,
    output logic                res_valid,
    output logic                res_match,
    output logic [IDX_W-1:0]    res_idx,
    output logic [VEC_W-1:0]    res_vec,
    output logic                res_ts
);

    typedef struct packed {
        logic              valid;
        logic              match;
        logic [IDX_W-1:0]  idx;
        logic [VEC_W-1:0]  vec;
        logic              ts;
    } res_t;

    mpm_mode_e                      ent_mode [N_ENT];
    logic [N_ENT-1:0][MAC_W-1:0]    ent_mac;
    logic [N_ENT-1:0][ETYPE_W-1:0]  ent_etype;
    logic [N_ENT-1:0][VEC_W-1:0]    ent_vec;
    logic                           ts_en;
    logic [N_ENT-1:0]               hits;
    logic                           found;
    logic [IDX_W-1:0]               win;

    res_t res_d, res_q;

    mpm_regs #(
        .N_ENT (N_ENT),
        .VEC_W (VEC_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ent_mode  (ent_mode),
        .ent_mac   (ent_mac),
        .ent_etype (ent_etype),
        .ent_vec   (ent_vec),
        .ts_en     (ts_en)
    );

    generate
        for (genvar g = 0; g < int'(N_ENT); g++) begin : g_cmp
            mpm_entry_cmp u_cmp (
                .mode      (ent_mode[g]),
                .key_mac   (ent_mac[g]),
                .key_etype (ent_etype[g]),
                .frm_mac   (hdr_dmac),
                .frm_etype (hdr_etype),
                .hit       (hits[g])
            );
        end
    endgenerate

    mpm_prio #(
        .N_ENT (N_ENT)
    ) u_prio (
        .hits  (hits),
        .found (found),
        .win   (win)
    );

    always_comb begin
        res_d = '0;
        if (hdr_valid) begin
            res_d.valid = 1'b1;
            if (found) begin
                res_d.match = 1'b1;
                res_d.idx   = win;
                res_d.vec   = ent_vec[win];
                res_d.ts    = ts_en && (win == '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.valid;
    assign res_match = res_q.match;
    assign res_idx   = res_q.idx;
    assign res_vec   = res_q.vec;
    assign res_ts    = res_q.ts;

endmodule

// File: rtl/mpm_checker.sv
module mpm_checker #(
    parameter int unsigned N_ENT = 6,
    parameter int unsigned VEC_W = 32,
    localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hdr_valid,
    input logic              res_valid,
    input logic              res_match,
    input logic [IDX_W-1:0]  res_idx,
    input logic [VEC_W-1:0]  res_vec,
    input logic              res_ts
);

    // R7: no match leaves index, vector and timestamp request at zero
    a_r7_nomatch_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !res_match |-> (res_idx == '0 && res_vec == '0 && !res_ts));

    // R8: timestamp request only for a win by entry 0
    a_r8_ts_entry0: assert property (@(posedge clk) disable iff (!rst_n)
        res_ts |-> (res_match && res_idx == '0));

    // R9: a result follows a header strobe one cycle earlier
    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> res_valid);

    // R9: no result without a strobe in the cycle before
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !res_valid);

    // R9: match only inside a result cycle
    a_r9_match_in_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_match |-> res_valid);

    // R6: reported index names an existing entry
    a_r6_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        res_match |-> (int'(res_idx) < int'(N_ENT)));

endmodule

bind mpm_classifier mpm_checker #(
    .N_ENT (N_ENT),
    .VEC_W (VEC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_valid (hdr_valid),
    .res_valid (res_valid),
    .res_match (res_match),
    .res_idx   (res_idx),
    .res_vec   (res_vec),
    .res_ts    (res_ts)
);

// File: tb/sim_mpm_classifier.sv
module sim_mpm_classifier;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        hdr_valid = 1'b0;
    logic [47:0] hdr_dmac = '0;
    logic [15:0] hdr_etype = '0;
    logic        res_valid, res_match, res_ts;
    logic [2:0]  res_idx;
    logic [31:0] res_vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench copy of the configuration, per the register map in R2, R3, R10
    logic [15:0] m_ctrl;
    logic [31:0] m_lo  [6];
    logic [31:0] m_hi  [6];
    logic [31:0] m_vec [6];

    always #5 clk = ~clk;

    mpm_classifier u0 (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
        .hdr_valid, .hdr_dmac, .hdr_etype,
        .res_valid, .res_match, .res_idx, .res_vec, .res_ts
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic wr(logic [1:0] kind, int ent, logic [31:0] data);
        cfg_we    = 1'b1;
        cfg_addr  = {kind, 3'(ent)};
        cfg_wdata = data;
        if (ent < 6) begin
            case (kind)
                2'd0: m_ctrl = data[15:0];
                2'd1: m_lo[ent] = data;
                2'd2: m_hi[ent] = data;
                default: m_vec[ent] = data;
            endcase
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_mode(int ent, logic [1:0] mode);
        logic [15:0] c = m_ctrl;
        c[2*ent +: 2] = mode;
        wr(2'd0, 0, {16'h0, c});
    endtask

    task automatic set_key(int ent, logic [47:0] mac, logic [15:0] et);
        wr(2'd1, ent, mac[31:0]);
        wr(2'd2, ent, {et, mac[47:32]});
    endtask

    function automatic void model(input logic [47:0] mac, input logic [15:0] et,
                                  output logic m, output logic [2:0] idx,
                                  output logic [31:0] vec, output logic ts);
        m = 1'b0; idx = '0; vec = '0; ts = 1'b0;
        for (int i = 5; i >= 0; i--) begin
            logic [1:0] md = m_ctrl[2*i +: 2];
            logic me = (mac == {m_hi[i][15:0], m_lo[i]});
            logic ee = (et == m_hi[i][31:16]);
            logic h = (md == 2'd1 && me) || (md == 2'd2 && ee) || (md == 2'd3 && me && ee);
            if (h) begin
                m = 1'b1; idx = 3'(i); vec = m_vec[i];
            end
        end
        ts = m && idx == 3'd0 && m_ctrl[15];
    endfunction

    // Drive one header and compare the result one cycle later
    task automatic frame(string req, logic [47:0] mac, logic [15:0] et);
        logic em; logic [2:0] ei; logic [31:0] ev; logic et_s;
        model(mac, et, em, ei, ev, et_s);
        hdr_valid = 1'b1; hdr_dmac = mac; hdr_etype = et;
        @(negedge clk);
        hdr_valid = 1'b0;
        check({req, " valid"}, 64'(res_valid), 64'd1);
        check({req, " match"}, 64'(res_match), 64'(em));
        check({req, " idx"},   64'(res_idx),   64'(ei));
        check({req, " vec"},   64'(res_vec),   64'(ev));
        check({req, " ts"},    64'(res_ts),    64'(et_s));
    endtask

    localparam logic [47:0] MAC_A = 48'h0011_2233_4455;
    localparam logic [47:0] MAC_B = 48'h0A0B_0C0D_0E0F;
    localparam logic [47:0] MAC_C = 48'h01_1B19_0000_00;
    localparam logic [15:0] ET_PTP = 16'h88F7;

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        m_ctrl = '0;
        for (int i = 0; i < 6; i++) begin
            m_lo[i] = '0; m_hi[i] = '0; m_vec[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state of every output
        check("R1 reset valid", 64'(res_valid), 0);
        check("R1 reset match", 64'(res_match), 0);
        check("R1 reset vec",   64'(res_vec), 0);
        check("R1 reset ts",    64'(res_ts), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: all-zero header equals all-zero keys but entries are disabled
        frame("R1", 48'h0, 16'h0);

        // R2: MAC compare, CPU port 8 in vector
        set_key(2, MAC_A, 16'h0800);
        wr(2'd3, 2, 32'h0000_0100);
        set_mode(2, 2'd1);
        frame("R2", MAC_A, 16'h1234);
        check("R2 idx2", 64'(res_idx), 64'd2);
        frame("R7", MAC_B, 16'h0800);
        check("R7 nomatch", 64'(res_match), 0);

        // R3: EtherType compare; R6 lower entry wins over entry 2
        set_key(1, MAC_C, ET_PTP);
        wr(2'd3, 1, 32'h0000_0020);
        set_mode(1, 2'd2);
        frame("R3", MAC_B, ET_PTP);
        check("R3 vec", 64'(res_vec), 64'h20);
        frame("R6", MAC_A, ET_PTP);
        check("R6 lowest", 64'(res_idx), 64'd1);

        // R4: both fields
        set_key(3, MAC_B, 16'h0800);
        wr(2'd3, 3, 32'h8000_0001);
        set_mode(3, 2'd3);
        frame("R4", MAC_B, 16'h0800);
        check("R4 both", 64'(res_idx), 64'd3);
        frame("R4", MAC_B, 16'h86DD);
        check("R4 et diff", 64'(res_match), 0);
        frame("R4", MAC_C, 16'h0800);
        check("R4 mac diff", 64'(res_match), 0);

        // R5: keys equal but mode 0
        set_key(4, MAC_C, 16'h0806);
        wr(2'd3, 4, 32'hFFFF_FFFF);
        frame("R5", MAC_C, 16'h0806);
        check("R5 off", 64'(res_match), 0);

        // R8: timestamp for entry 0 only when bit 15 set
        set_key(0, MAC_A, ET_PTP);
        wr(2'd3, 0, 32'h0000_0080);
        set_mode(0, 2'd2);
        frame("R8", MAC_B, ET_PTP);
        check("R8 no enable", 64'(res_ts), 0);
        wr(2'd0, 0, {16'h0, m_ctrl | 16'h8000});
        frame("R8", MAC_B, ET_PTP);
        check("R8 ts", 64'(res_ts), 1);
        frame("R8", MAC_A, 16'h1111);
        check("R8 entry2 no ts", 64'(res_ts), 0);

        // R9: result lasts one cycle
        @(negedge clk);
        check("R9 pulse valid", 64'(res_valid), 0);
        check("R9 pulse match", 64'(res_match), 0);
        check("R9 pulse vec",   64'(res_vec), 0);

        // R10: write in the same cycle as a header uses old config
        hdr_valid = 1'b1; hdr_dmac = MAC_B; hdr_etype = ET_PTP;
        cfg_we = 1'b1; cfg_addr = 5'd0; cfg_wdata = 32'h0;
        @(negedge clk);
        hdr_valid = 1'b0; cfg_we = 1'b0;
        check("R10 old cfg match", 64'(res_match), 1);
        check("R10 old cfg idx", 64'(res_idx), 0);
        m_ctrl = '0;
        frame("R10", MAC_B, ET_PTP);
        check("R10 new cfg", 64'(res_match), 0);

        // R10: mode field position of entry 5 (control bits 11:10)
        set_key(5, MAC_C, 16'h2222);
        wr(2'd3, 5, 32'h0000_0004);
        wr(2'd0, 0, 32'h0000_0400);
        frame("R10", MAC_C, 16'h3333);
        check("R10 field5", 64'(res_idx), 64'd5);
        // R10: entries 6 and 7 do not exist; writes must not alias
        wr(2'd3, 6, 32'hDEAD_BEEF);
        wr(2'd3, 7, 32'hDEAD_BEEF);
        wr(2'd1, 6, 32'h0);
        wr(2'd2, 7, 32'h0);
        frame("R10", MAC_C, 16'h3333);
        check("R10 no alias vec", 64'(res_vec), 64'h4);

        // Random mix, R6 priority and R2/R3/R4/R7/R8 together
        for (int n = 0; n < 600; n++) begin
            logic [47:0] macs [4];
            logic [15:0] ets  [4];
            macs[0] = MAC_A; macs[1] = MAC_B; macs[2] = MAC_C; macs[3] = 48'hFFFF_FFFF_FFFF;
            ets[0] = ET_PTP; ets[1] = 16'h0800; ets[2] = 16'h86DD; ets[3] = 16'h0000;
            if ($urandom_range(0, 2) == 0) begin
                int e = int'($urandom_range(0, 5));
                case ($urandom_range(0, 3))
                    0: set_mode(e, 2'($urandom_range(0, 3)));
                    1: set_key(e, macs[$urandom_range(0, 3)], ets[$urandom_range(0, 3)]);
                    2: wr(2'd3, e, $urandom);
                    default: wr(2'd0, 0, {16'h0, m_ctrl ^ 16'h8000});
                endcase
            end else begin
                frame("R6 random", macs[$urandom_range(0, 3)], ets[$urandom_range(0, 3)]);
            end
        end
        finish_run();
    end

endmodule